// File: doc/BRIEF.md
# Flash Page Operation Sequencer

This block is the self-timed engine behind a paged flash memory with two page-sized SRAM buffers. A front end that has already decoded a command presents an opcode and a 24-bit address while chip select is held low. When chip select is released, the block starts the command. It can copy a main-memory page into a buffer, compare a page against a buffer, program a page from a buffer with or without a preceding erase, or first fill a buffer from incoming bytes and then erase and program. The main memory is a small parameterised array, so the whole engine can be simulated.

Each operation walks the page one byte per clock. Erase and program phases are followed by wait periods whose lengths are parameters. During the whole operation the status byte reports busy. A compare leaves its verdict in status bit 6. Buffer contents can be read back at any time through a registered read port.

Top module: `flash_page_sequencer`

## Requirements
- R1: After reset, `status_o` is 8'h80 and every byte of both buffers and of every page is 8'hFF.
- R2: A command starts only at a clock edge where `cs_n_i` is high after having been low at the previous edge, and only if `op_i` is one of 53h, 55h, 60h, 61h, 82h, 83h, 85h, 86h, 88h, 89h. Ready drops in the cycle after that edge. Any other opcode starts nothing.
- R3: Opcode 53h copies the addressed page into buffer 1, and 55h copies it into buffer 2. Ready stays low for BUF_BYTES cycles.
- R4: Opcodes 60h and 61h compare the page with buffer 1 or buffer 2 over BUF_BYTES cycles. Status bit 6 becomes 0 on a full match and 1 otherwise. It changes only at the edge where ready returns and otherwise holds its value.
- R5: Opcodes 83h and 86h erase the page to all ones and then copy buffer 1 or buffer 2 into it. Ready stays low for 2*BUF_BYTES+ERASE_CYCLES+PROG_CYCLES cycles.
- R6: Opcodes 88h and 89h leave the page equal to its old contents bitwise ANDed with buffer 1 or buffer 2. Ready stays low for BUF_BYTES+PROG_CYCLES cycles.
- R7: Under opcodes 82h (buffer 1) and 85h (buffer 2), each cycle with `din_valid_i` high while `cs_n_i` is low stores `din_i` into the buffer. The first byte goes to `addr_i[8:0]` and each following byte to the next address, wrapping from BUF_BYTES-1 to 0. On release the command then runs as in R5. For every command the page number is `addr_i[20:9]`.
- R8: Page-number bits at and above log2(PAGES) are ignored, so page P and page P+PAGES address the same page.
- R9: While ready is low, chip-select releases and incoming data bytes have no effect.
- R10: Status bit 7 is ready (1 = idle), bit 6 is the compare verdict, and bits 5..0 read 0.
- R11: `rd_data_o` shows the byte at `rd_addr_i` of the buffer picked by `rd_sel_i` (0 = buffer 1) one cycle after they are applied.
- R12: A program step never turns a page bit from 0 to 1; only the erase phase writes 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low chip select; its release starts a command |
| op_i | input | 8 | Decoded command opcode |
| addr_i | input | 24 | Command address: page in [20:9], buffer start in [8:0] |
| din_valid_i | input | 1 | Data byte strobe for buffer-load commands |
| din_i | input | 8 | Data byte to load |
| rd_sel_i | input | 1 | Buffer to read (0 = buffer 1, 1 = buffer 2) |
| rd_addr_i | input | 9 | Buffer byte address to read |
| rd_data_o | output | 8 | Registered buffer read data |
| status_o | output | 8 | Status: bit 7 ready, bit 6 compare mismatch |

## Verification
The bound checker watches four things on every clock. Ready may fall only right after a chip-select release. The compare bit may move only when an operation completes. The array and the buffers are written only while busy. A program write never sets a bit that the page had cleared. The data outcomes are shown only by bench scenarios that compare buffer and page contents with a behavioural model. These outcomes are page copies, AND-programming, load wrap-around, page aliasing, and the fact that commands and bytes issued while busy are dropped. The same scenarios check the exact busy length of each command.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_XFER,
    OP_CMP,
    OP_PROG_ERASE,
    OP_PROG_KEEP
  } op_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_CMP,
    ST_ERASE,
    ST_EWAIT,
    ST_PROG,
    ST_PWAIT
  } eng_state_e;

  typedef struct packed {
    op_kind_e kind;
    logic     buf_sel;
    logic     loads;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [7:0] op);
    cmd_t c;
    c.kind    = OP_NONE;
    c.buf_sel = 1'b0;
    c.loads   = 1'b0;
    case (op)
      8'h53: c.kind = OP_XFER;
      8'h55: begin c.kind = OP_XFER;       c.buf_sel = 1'b1; end
      8'h60: c.kind = OP_CMP;
      8'h61: begin c.kind = OP_CMP;        c.buf_sel = 1'b1; end
      8'h83: c.kind = OP_PROG_ERASE;
      8'h86: begin c.kind = OP_PROG_ERASE; c.buf_sel = 1'b1; end
      8'h88: c.kind = OP_PROG_KEEP;
      8'h89: begin c.kind = OP_PROG_KEEP;  c.buf_sel = 1'b1; end
      8'h82: begin c.kind = OP_PROG_ERASE; c.loads = 1'b1; end
      8'h85: begin c.kind = OP_PROG_ERASE; c.loads = 1'b1; c.buf_sel = 1'b1; end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/fps_front.sv
module fps_front
  import fps_pkg::*;
#(
  parameter int BUF_BYTES = 264,
  parameter int BA_W      = 9,
  parameter int PAGE_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic [7:0]        op_i,
  input  logic [23:0]       addr_i,
  input  logic              din_valid_i,
  input  logic [7:0]        din_i,
  input  logic              ready_i,
  output logic              start_o,
  output op_kind_e          start_kind_o,
  output logic              start_sel_o,
  output logic [PAGE_W-1:0] start_page_o,
  output logic              load_we_o,
  output logic              load_sel_o,
  output logic [BA_W-1:0]   load_addr_o,
  output logic [7:0]        load_data_o
);

  localparam logic [BA_W-1:0] LAST_ADDR = BA_W'(BUF_BYTES - 1);

  cmd_t            cmd;
  logic            cs_q;
  logic            first_q;
  logic [BA_W-1:0] ptr_q;
  logic [BA_W-1:0] cur_addr;
  logic [BA_W-1:0] nxt_addr;
  logic            load_take;
  logic            unused_addr_hi;

  assign cmd            = decode_cmd(op_i);
  assign unused_addr_hi = ^addr_i[23:BA_W+PAGE_W];

  // release edge of chip select, only while idle
  assign start_o      = !cs_q && cs_n_i && ready_i && (cmd.kind != OP_NONE);
  assign start_kind_o = cmd.kind;
  assign start_sel_o  = cmd.buf_sel;
  assign start_page_o = addr_i[BA_W +: PAGE_W];

  assign load_take = !cs_n_i && din_valid_i && ready_i && cmd.loads;
  assign cur_addr  = first_q ? addr_i[BA_W-1:0] : ptr_q;
  assign nxt_addr  = (cur_addr >= LAST_ADDR) ? '0 : cur_addr + 1'b1;

  assign load_we_o   = load_take && (cur_addr <= LAST_ADDR);
  assign load_sel_o  = cmd.buf_sel;
  assign load_addr_o = cur_addr;
  assign load_data_o = din_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= 1'b1;
      first_q <= 1'b1;
      ptr_q   <= '0;
    end else begin
      cs_q <= cs_n_i;
      if (cs_n_i) begin
        first_q <= 1'b1;
      end else if (load_take) begin
        first_q <= 1'b0;
        ptr_q   <= nxt_addr;
      end
    end
  end

endmodule

// File: rtl/fps_engine.sv
module fps_engine
  import fps_pkg::*;
#(
  parameter int BUF_BYTES    = 264,
  parameter int BA_W         = 9,
  parameter int PAGE_W       = 3,
  parameter int ERASE_CYCLES = 40,
  parameter int PROG_CYCLES  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  op_kind_e          start_kind_i,
  input  logic              start_sel_i,
  input  logic [PAGE_W-1:0] start_page_i,
  input  logic [7:0]        arr_rdata_i,
  input  logic [7:0]        buf_rdata_i,
  output logic              ready_o,
  output logic              cmp_o,
  output logic              sel_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [BA_W-1:0]   idx_o,
  output logic              arr_we_o,
  output logic [7:0]        arr_wdata_o,
  output logic              buf_we_o,
  output logic [7:0]        buf_wdata_o
);

  localparam int CNT_MAX = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [BA_W-1:0]  LAST_IDX = BA_W'(BUF_BYTES - 1);
  localparam logic [CNT_W-1:0] E_END    = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] P_END    = CNT_W'(PROG_CYCLES - 1);

  eng_state_e        st_q;
  logic [BA_W-1:0]   idx_q;
  logic [BA_W-1:0]   idx_nxt;
  logic [CNT_W-1:0]  cnt_q;
  logic [PAGE_W-1:0] page_q;
  logic              sel_q;
  logic              diff_q;
  logic              cmp_q;
  logic              last;
  logic              neq;

  assign last    = (idx_q == LAST_IDX);
  assign idx_nxt = last ? '0 : idx_q + 1'b1;
  assign neq     = (arr_rdata_i != buf_rdata_i);

  assign ready_o     = (st_q == ST_IDLE);
  assign cmp_o       = cmp_q;
  assign sel_o       = sel_q;
  assign page_o      = page_q;
  assign idx_o       = idx_q;
  assign arr_we_o    = (st_q == ST_ERASE) || (st_q == ST_PROG);
  // programming can only clear bits
  assign arr_wdata_o = (st_q == ST_ERASE) ? 8'hFF : (arr_rdata_i & buf_rdata_i);
  assign buf_we_o    = (st_q == ST_XFER);
  assign buf_wdata_o = arr_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      cnt_q  <= '0;
      page_q <= '0;
      sel_q  <= 1'b0;
      diff_q <= 1'b0;
      cmp_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            idx_q  <= '0;
            diff_q <= 1'b0;
            page_q <= start_page_i;
            sel_q  <= start_sel_i;
            case (start_kind_i)
              OP_XFER:       st_q <= ST_XFER;
              OP_CMP:        st_q <= ST_CMP;
              OP_PROG_ERASE: st_q <= ST_ERASE;
              OP_PROG_KEEP:  st_q <= ST_PROG;
              default:       st_q <= ST_IDLE;
            endcase
          end
        end
        ST_XFER: begin
          idx_q <= idx_nxt;
          if (last) st_q <= ST_IDLE;
        end
        ST_CMP: begin
          idx_q  <= idx_nxt;
          diff_q <= diff_q | neq;
          if (last) begin
            cmp_q <= diff_q | neq;
            st_q  <= ST_IDLE;
          end
        end
        ST_ERASE: begin
          idx_q <= idx_nxt;
          if (last) begin
            st_q  <= ST_EWAIT;
            cnt_q <= '0;
          end
        end
        ST_EWAIT: begin
          if (cnt_q == E_END) begin
            st_q  <= ST_PROG;
            idx_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PROG: begin
          idx_q <= idx_nxt;
          if (last) begin
            st_q  <= ST_PWAIT;
            cnt_q <= '0;
          end
        end
        ST_PWAIT: begin
          if (cnt_q == P_END) st_q <= ST_IDLE;
          else                cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fps_buffer.sv
module fps_buffer #(
  parameter int BUF_BYTES = 264,
  parameter int BA_W      = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [BA_W-1:0] waddr_i,
  input  logic [7:0]      wdata_i,
  input  logic [BA_W-1:0] eaddr_i,
  output logic [7:0]      edata_o,
  input  logic [BA_W-1:0] haddr_i,
  output logic [7:0]      hdata_o
);

  logic [7:0] mem_q [BUF_BYTES];

  assign edata_o = (int'(eaddr_i) < BUF_BYTES) ? mem_q[eaddr_i] : 8'h00;
  assign hdata_o = (int'(haddr_i) < BUF_BYTES) ? mem_q[haddr_i] : 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BUF_BYTES; i++) mem_q[i] <= 8'hFF;
    end else if (we_i && (int'(waddr_i) < BUF_BYTES)) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

endmodule

// File: rtl/fps_array.sv
module fps_array #(
  parameter int PAGES     = 8,
  parameter int BUF_BYTES = 264,
  parameter int BA_W      = 9,
  parameter int PAGE_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [BA_W-1:0]   addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);

  localparam int MEM_N = PAGES * BUF_BYTES;
  localparam int IDX_W = $clog2(MEM_N);

  logic [7:0]       cell_q [MEM_N];
  logic [IDX_W-1:0] flat;

  assign flat    = IDX_W'(page_i) * IDX_W'(BUF_BYTES) + IDX_W'(addr_i);
  assign rdata_o = (int'(flat) < MEM_N) ? cell_q[flat] : 8'hFF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_N; i++) cell_q[i] <= 8'hFF;
    end else if (we_i && (int'(flat) < MEM_N)) begin
      cell_q[flat] <= wdata_i;
    end
  end

endmodule

// File: rtl/flash_page_sequencer.sv
module flash_page_sequencer
  import fps_pkg::*;
#(
  parameter int PAGES        = 8,
  parameter int BUF_BYTES    = 264,
  parameter int ERASE_CYCLES = 40,
  parameter int PROG_CYCLES  = 20,
  localparam int BA_W        = $clog2(BUF_BYTES),
  localparam int PAGE_W      = $clog2(PAGES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_n_i,
  input  logic [7:0]      op_i,
  input  logic [23:0]     addr_i,
  input  logic            din_valid_i,
  input  logic [7:0]      din_i,
  input  logic            rd_sel_i,
  input  logic [BA_W-1:0] rd_addr_i,
  output logic [7:0]      rd_data_o,
  output logic [7:0]      status_o
);

  logic              start;
  op_kind_e          start_kind;
  logic              start_sel;
  logic [PAGE_W-1:0] start_page;
  logic              load_we;
  logic              load_sel;
  logic [BA_W-1:0]   load_addr;
  logic [7:0]        load_data;
  logic              ready;
  logic              cmp_bit;
  logic              eng_sel;
  logic [PAGE_W-1:0] eng_page;
  logic [BA_W-1:0]   eng_idx;
  logic              arr_we;
  logic [7:0]        arr_wdata;
  logic [7:0]        arr_rdata;
  logic              eng_buf_we;
  logic [7:0]        eng_buf_wdata;
  logic [7:0]        buf_rdata;
  logic [7:0]        eng_rd  [2];
  logic [7:0]        host_rd [2];
  logic              rd_q_sel;
  logic [7:0]        rd_q;

  fps_front #(
    .BUF_BYTES(BUF_BYTES), .BA_W(BA_W), .PAGE_W(PAGE_W)
  ) u_front (
    .clk_i, .rst_ni, .cs_n_i, .op_i, .addr_i, .din_valid_i, .din_i,
    .ready_i      (ready),
    .start_o      (start),
    .start_kind_o (start_kind),
    .start_sel_o  (start_sel),
    .start_page_o (start_page),
    .load_we_o    (load_we),
    .load_sel_o   (load_sel),
    .load_addr_o  (load_addr),
    .load_data_o  (load_data)
  );

  fps_engine #(
    .BUF_BYTES(BUF_BYTES), .BA_W(BA_W), .PAGE_W(PAGE_W),
    .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)
  ) u_engine (
    .clk_i, .rst_ni,
    .start_i      (start),
    .start_kind_i (start_kind),
    .start_sel_i  (start_sel),
    .start_page_i (start_page),
    .arr_rdata_i  (arr_rdata),
    .buf_rdata_i  (buf_rdata),
    .ready_o      (ready),
    .cmp_o        (cmp_bit),
    .sel_o        (eng_sel),
    .page_o       (eng_page),
    .idx_o        (eng_idx),
    .arr_we_o     (arr_we),
    .arr_wdata_o  (arr_wdata),
    .buf_we_o     (eng_buf_we),
    .buf_wdata_o  (eng_buf_wdata)
  );

  fps_array #(
    .PAGES(PAGES), .BUF_BYTES(BUF_BYTES), .BA_W(BA_W), .PAGE_W(PAGE_W)
  ) u_array (
    .clk_i, .rst_ni,
    .we_i    (arr_we),
    .page_i  (eng_page),
    .addr_i  (eng_idx),
    .wdata_i (arr_wdata),
    .rdata_o (arr_rdata)
  );

  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic            we;
    logic [BA_W-1:0] waddr;
    logic [7:0]      wdata;

    // engine writes only while busy, loads only while idle
    assign we    = (eng_buf_we && (eng_sel == 1'(b))) || (load_we && (load_sel == 1'(b)));
    assign waddr = eng_buf_we ? eng_idx : load_addr;
    assign wdata = eng_buf_we ? eng_buf_wdata : load_data;

    fps_buffer #(
      .BUF_BYTES(BUF_BYTES), .BA_W(BA_W)
    ) u_buf (
      .clk_i, .rst_ni,
      .we_i    (we),
      .waddr_i (waddr),
      .wdata_i (wdata),
      .eaddr_i (eng_idx),
      .edata_o (eng_rd[b]),
      .haddr_i (rd_addr_i),
      .hdata_o (host_rd[b])
    );
  end

  assign buf_rdata = eng_rd[eng_sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q_sel <= 1'b0;
      rd_q     <= 8'h00;
    end else begin
      rd_q_sel <= rd_sel_i;
      rd_q     <= host_rd[rd_sel_i];
    end
  end

  logic unused_rd_sel;
  assign unused_rd_sel = rd_q_sel;

  assign rd_data_o = rd_q;
  assign status_o  = {ready, cmp_bit, 6'b00_0000};

endmodule

// File: rtl/fps_checks.sv
module fps_checks (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_n_i,
  input logic [7:0] status_o,
  input logic       arr_we,
  input logic [7:0] arr_wdata,
  input logic [7:0] arr_rdata,
  input logic       eng_buf_we
);

  assert_start_after_cs_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[7]) |-> ($past(cs_n_i) && !$past(cs_n_i, 2)));

  assert_cmp_moves_at_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status_o[6]) |-> $rose(status_o[7]));

  assert_array_write_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we |-> !status_o[7]);

  assert_buffer_fill_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_buf_we |-> !status_o[7]);

  assert_no_bit_set_by_program_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_we && (arr_wdata != 8'hFF)) |-> ((arr_wdata & ~arr_rdata) == 8'h00));

endmodule

bind flash_page_sequencer fps_checks i_checks (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_n_i     (cs_n_i),
  .status_o   (status_o),
  .arr_we     (arr_we),
  .arr_wdata  (arr_wdata),
  .arr_rdata  (arr_rdata),
  .eng_buf_we (eng_buf_we)
);

// File: tb/test_flash_page_sequencer.sv
`timescale 1ns/1ps
module test_flash_page_sequencer;

  localparam int PAGES = 8;
  localparam int BUF   = 264;
  localparam int E     = 40;
  localparam int P     = 20;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_n_i = 1'b1;
  logic [7:0] op_i = 8'h00;
  logic [23:0] addr_i = '0;
  logic       din_valid_i = 1'b0;
  logic [7:0] din_i = 8'h00;
  logic       rd_sel_i = 1'b0;
  logic [8:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic [7:0] status_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  int mem_m [PAGES*BUF];
  int buf_m [2*BUF];
  int busy_left = 0;
  bit exp_cmp = 0;
  bit pend = 0;
  bit pend_val = 0;
  bit m_cs_prev = 1;
  bit m_first = 1;
  int m_ptr = 0;

  always #5 clk_i = ~clk_i;

  flash_page_sequencer #(
    .PAGES(PAGES), .BUF_BYTES(BUF), .ERASE_CYCLES(E), .PROG_CYCLES(P)
  ) i_flash_page_sequencer (
    .clk_i, .rst_ni, .cs_n_i, .op_i, .addr_i, .din_valid_i, .din_i,
    .rd_sel_i, .rd_addr_i, .rd_data_o, .status_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic m_start(input int op, input int addr);
    int p;
    int s;
    bit d;
    p = ((addr >> 9) & 12'hFFF) % PAGES;
    case (op)
      'h53, 'h55: begin
        s = (op == 'h55);
        for (int i = 0; i < BUF; i++) buf_m[s*BUF+i] = mem_m[p*BUF+i];
        busy_left = BUF;
      end
      'h60, 'h61: begin
        s = op - 'h60;
        d = 0;
        for (int i = 0; i < BUF; i++) if (buf_m[s*BUF+i] != mem_m[p*BUF+i]) d = 1;
        pend = 1; pend_val = d;
        busy_left = BUF;
      end
      'h82, 'h83, 'h85, 'h86: begin
        s = (op == 'h85 || op == 'h86);
        for (int i = 0; i < BUF; i++) mem_m[p*BUF+i] = buf_m[s*BUF+i];
        busy_left = 2*BUF + E + P;
      end
      'h88, 'h89: begin
        s = op - 'h88;
        for (int i = 0; i < BUF; i++) mem_m[p*BUF+i] = mem_m[p*BUF+i] & buf_m[s*BUF+i];
        busy_left = BUF + P;
      end
      default: ;
    endcase
  endtask

  always @(posedge clk_i) begin
    if (rst_ni) begin
      if (busy_left > 0) begin
        busy_left--;
        if (busy_left == 0 && pend) begin exp_cmp = pend_val; pend = 0; end
      end else begin
        if (!m_cs_prev && cs_n_i) m_start(op_i, addr_i);
        if (!cs_n_i && din_valid_i && (op_i == 8'h82 || op_i == 8'h85)) begin
          int a;
          a = m_first ? int'(addr_i[8:0]) : m_ptr;
          if (a < BUF) buf_m[(op_i == 8'h85)*BUF + a] = din_i;
          m_ptr = (a >= BUF-1) ? 0 : a + 1;
          m_first = 0;
        end
      end
      if (cs_n_i) m_first = 1;
      m_cs_prev = cs_n_i;
    end
  end

  // every-cycle status comparison (R2 R4 R9 timing, R10 layout)
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      logic [7:0] exp_s;
      exp_s = {busy_left == 0, exp_cmp, 6'b0};
      chk(status_o === exp_s, "R10 status (R2 R4 R9 timing)", status_o, exp_s);
    end
  end

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 31 + k * 17 + 3) ^ (k >> 2));
  endfunction

  task automatic send(input int o, input int a, input int n, input int seed);
    @(negedge clk_i);
    cs_n_i = 1'b0; op_i = 8'(o); addr_i = 24'(a);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      din_valid_i = 1'b1; din_i = pat(seed, k);
    end
    @(negedge clk_i);
    din_valid_i = 1'b0;
    @(negedge clk_i);
    cs_n_i = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wait_idle();
    while (!status_o[7]) @(negedge clk_i);
  endtask

  task automatic check_buf(input int s, input string req);
    for (int i = 0; i < BUF; i++) begin
      rd_sel_i = 1'(s); rd_addr_i = 9'(i);
      @(negedge clk_i);
      chk(rd_data_o === 8'(buf_m[s*BUF+i]), req, rd_data_o, buf_m[s*BUF+i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R2: actual hung expected idle");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < PAGES*BUF; i++) mem_m[i] = 'hFF;
    for (int i = 0; i < 2*BUF; i++) buf_m[i] = 'hFF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(status_o === 8'h80, "R1 reset status", status_o, 8'h80);
    rd_sel_i = 1'b1; rd_addr_i = 9'd5;
    @(negedge clk_i);
    chk(rd_data_o === 8'hFF, "R1 R11 reset buffer", rd_data_o, 8'hFF);

    // load-program with wrap: buffer 1, page 3, start 260, 12 bytes
    send('h82, (3 << 9) | 260, 12, 1);
    chk(status_o[7] === 1'b0, "R2 busy after release", status_o[7], 0);
    wait_idle();
    check_buf(0, "R7 loaded buffer with wrap");
    send('h55, 3 << 9, 0, 0);
    wait_idle();
    check_buf(1, "R3 R5 R11 page copy to buffer 2");

    // compares: mismatch then match
    send('h61, 2 << 9, 0, 0);
    wait_idle();
    chk(status_o[6] === 1'b1, "R4 compare differs", status_o[6], 1);
    send('h60, 3 << 9, 0, 0);
    wait_idle();
    chk(status_o[6] === 1'b0, "R4 compare matches", status_o[6], 0);

    // program without erase: AND of page 3 with buffer 2
    send('h85, 5 << 9, 8, 7);
    wait_idle();
    send('h89, 3 << 9, 0, 0);
    wait_idle();
    send('h53, 3 << 9, 0, 0);
    wait_idle();
    check_buf(0, "R6 R12 program keeps cleared bits");

    // erase-program into page 1, read back through aliased page 9
    send('h86, 1 << 9, 0, 0);
    wait_idle();
    send('h53, (1 + PAGES) << 9, 0, 0);
    wait_idle();
    check_buf(0, "R5 R8 erase-program via aliased page");

    // commands and data while busy are dropped
    send('h61, 4 << 9, 0, 0);
    send('h55, 4 << 9, 0, 0);
    send('h85, 4 << 9, 6, 9);
    chk(status_o[7] === 1'b0, "R9 still in first command", status_o[7], 0);
    wait_idle();
    check_buf(1, "R9 buffer untouched while busy");
    chk(status_o[6] === 1'b1, "R4 compare page 4", status_o[6], 1);

    // unknown opcode starts nothing
    send('h84, 0, 0, 0);
    chk(status_o[7] === 1'b1, "R2 unknown opcode ignored", status_o[7], 1);
    repeat (4) @(negedge clk_i);
    chk(status_o === 8'hC0, "R10 status layout", status_o, 8'hC0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule